// File: doc/BRIEF.md
# Multichannel Digital Volume Ramp Controller

This block scales six signed PCM channels by a gain that is the sum of a shared master setting and a per-channel setting. Each setting is a two's complement integer number of decibels plus a two-bit field that adds 0, 0.25, 0.5 or 0.75 dB. The sum is clamped to the span from -127 dB to +24 dB. Internally the gain is held in eighth-dB units. The linear factor is taken as exactly 2 per 6 dB, so a gain of g eighths multiplies the sample by 2^(g/48). A gain at the -127 dB floor produces silence.

All channels share one sample strobe and arrive together as one frame. A 2-bit change mode sets how a channel's applied gain follows its target: at once, at the next zero crossing, as a soft ramp of one eighth-dB step every N frames, or as a soft ramp whose steps wait for zero crossings. A per-channel mute makes the target the floor, reached through the selected mode. A single-volume bit makes every channel take channel 0's setting. A settled flag per channel shows when the applied gain equals the target.

Top module: `vol_ramp_ctrl`

## Requirements
- R1: Target in quarter-dB = 4·master_int + master_frac + 4·chan_int + chan_frac, with the int fields signed 8-bit and the frac fields unsigned 2-bit. The target is clamped to [-508, +96] quarters (-127 dB to +24 dB). The output is round(x·2^(gain_dB/6)) with halves rounded upward, saturated to the signed sample width.
- R2: In mode 00 (immediate), a target change takes effect in the frame after the next strobe.
- R3: In mode 01 (zero cross), the applied gain holds until a frame whose sample sign differs from the previous frame's sign, or whose sample is zero. The new gain applies from the following frame.
- R4: In modes 01 and 11, a change is forced on the 512th consecutive pending frame that has no zero crossing.
- R5: In mode 10 (soft), the applied gain moves one 0.125 dB step toward the target once every ramp_rate+1 frames while it differs from the target. ramp_rate 0 gives one step per frame.
- R6: In mode 11, a soft-ramp step happens only on a zero-crossing frame, and only once at least ramp_rate+1 frames have passed since the last step.
- R7: With sngl_en = 1, every channel uses channel 0's int and frac fields; the master setting still adds.
- R8: A muted channel's target is the -127 dB floor, reached through the selected mode. At the floor the output is exactly zero.
- R9: settled[c] is 1 exactly when channel c's applied gain equals its current target.
- R10: out_vld is asserted for the one cycle after each smp_vld. Each output is scaled with the gain that was applied before that frame's update, and the gain changes only on strobes.
- R11: After reset, every applied gain is at the floor, out_vld is 0 and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Frame strobe |
| smp_in | input | NCH×DW | Signed input samples, one per channel |
| mst_int | input | 8 | Master gain, signed whole dB |
| mst_frac | input | 2 | Master gain, quarter-dB addend |
| ch_int | input | NCH×8 | Per-channel gain, signed whole dB |
| ch_frac | input | NCH×2 | Per-channel quarter-dB addend |
| ch_mute | input | NCH | Per-channel mute |
| sngl_en | input | 1 | All channels follow channel 0's setting |
| chg_mode | input | 2 | 00 immediate, 01 zero cross, 10 soft, 11 soft on zero cross |
| ramp_rate | input | RATE_W | Frames between soft steps, minus one |
| out_vld | output | 1 | Output frame valid |
| smp_out | output | NCH×DW | Scaled signed samples |
| settled | output | NCH | Applied gain equals target |

## Verification
In mode 11, the rate counter becoming ready and a zero crossing must fall on the same frame for a step to occur. The bench provokes this with ramp_rate 0. It feeds several same-sign frames, where no step may happen, and then flips the sample sign. It judges the result from the settled flag and from the gain seen on the next frame's output. A second overlap is the crossing frame itself: its own output must still carry the old gain while the new gain is latched for the frame after. The bench checks the outputs on both sides of that frame.

// File: rtl/vol_pkg.sv
package vol_pkg;
    localparam int INT_W     = 8;
    localparam int FRAC_W    = 2;
    localparam int GAIN_W    = 11;
    localparam int STEPS_6DB = 48;
    localparam int GMAX8     = 192;
    localparam int GMIN8     = -1016;
    localparam int QMAX      = GMAX8 / 2;
    localparam int QMIN      = GMIN8 / 2;
    localparam int HEAD      = GMAX8 / STEPS_6DB;
    localparam int MANT_W    = 31;
    localparam int MANT_FRAC = 30;
    localparam logic [63:0] STEP_RATIO = 64'd1058347801;

    typedef logic signed [GAIN_W-1:0] gain8_t;

    typedef enum logic [1:0] {
        CHG_NOW    = 2'b00,
        CHG_ZC     = 2'b01,
        CHG_SOFT   = 2'b10,
        CHG_SOFTZC = 2'b11
    } chg_mode_t;

    function automatic logic [MANT_W-1:0] mant_calc(input int k);
        logic [63:0] m;
        m = 64'd1 << MANT_FRAC;
        for (int i = 0; i < k; i++)
            m = (m * STEP_RATIO + (64'd1 << (MANT_FRAC - 1))) >> MANT_FRAC;
        return m[MANT_W-1:0];
    endfunction

    function automatic int clamp_q(input int q);
        if (q > QMAX) return QMAX;
        if (q < QMIN) return QMIN;
        return q;
    endfunction
endpackage

// File: rtl/vol_target.sv
module vol_target
    import vol_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic [INT_W-1:0]             mst_int,
    input  logic [FRAC_W-1:0]            mst_frac,
    input  logic [NCH-1:0][INT_W-1:0]    ch_int,
    input  logic [NCH-1:0][FRAC_W-1:0]   ch_frac,
    input  logic [NCH-1:0]               ch_mute,
    input  logic                         sngl_en,
    output logic [NCH-1:0][GAIN_W-1:0]   tgt
);
    logic [INT_W-1:0]  sel_int;
    logic [FRAC_W-1:0] sel_frac;
    int                q;
    int                g8;

    always_comb begin
        sel_int  = '0;
        sel_frac = '0;
        q        = 0;
        g8       = 0;
        tgt      = '0;
        for (int c = 0; c < NCH; c++) begin
            sel_int  = sngl_en ? ch_int[0]  : ch_int[c];
            sel_frac = sngl_en ? ch_frac[0] : ch_frac[c];
            q  = 4 * int'($signed(mst_int)) + int'(mst_frac)
               + 4 * int'($signed(sel_int)) + int'(sel_frac);
            g8 = ch_mute[c] ? GMIN8 : 2 * clamp_q(q);
            tgt[c] = GAIN_W'(g8);
        end
    end
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp
    import vol_pkg::*;
#(
    parameter int TMO    = 512,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic              x_neg,
    input  logic              x_zero,
    input  logic [1:0]        mode,
    input  logic [RATE_W-1:0] rate,
    input  logic [GAIN_W-1:0] tgt,
    output logic [GAIN_W-1:0] cur,
    output logic              settled
);
    localparam int TW = $clog2(TMO);

    gain8_t            cur_q, tgt_s, step_val;
    logic [RATE_W-1:0] cnt_q;
    logic [TW-1:0]     tmo_q;
    logic              prev_neg_q;
    logic              pending, zc, tmo_hit, zc_ok, rate_ok;
    chg_mode_t         mode_e;

    assign mode_e   = chg_mode_t'(mode);
    assign tgt_s    = $signed(tgt);
    assign pending  = cur_q != tgt_s;
    assign zc       = (x_neg != prev_neg_q) || x_zero;
    assign tmo_hit  = tmo_q == TW'(TMO - 1);
    assign zc_ok    = zc || tmo_hit;
    assign rate_ok  = cnt_q >= rate;
    assign step_val = (tgt_s > cur_q) ? cur_q + gain8_t'(1) : cur_q - gain8_t'(1);
    assign cur      = cur_q;
    assign settled  = !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= gain8_t'(GMIN8);
            cnt_q      <= '0;
            tmo_q      <= '0;
            prev_neg_q <= 1'b0;
        end else if (vld) begin
            prev_neg_q <= x_neg;
            if (!pending) begin
                cnt_q <= '0;
                tmo_q <= '0;
            end else begin
                unique case (mode_e)
                    CHG_NOW: begin
                        cur_q <= tgt_s;
                        cnt_q <= '0;
                        tmo_q <= '0;
                    end
                    CHG_ZC: begin
                        if (zc_ok) begin
                            cur_q <= tgt_s;
                            tmo_q <= '0;
                        end else begin
                            tmo_q <= tmo_q + 1'b1;
                        end
                    end
                    CHG_SOFT: begin
                        if (rate_ok) begin
                            cur_q <= step_val;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    CHG_SOFTZC: begin
                        if (rate_ok && zc_ok) begin
                            cur_q <= step_val;
                            cnt_q <= '0;
                            tmo_q <= '0;
                        end else begin
                            if (!rate_ok) cnt_q <= cnt_q + 1'b1;
                            if (!zc_ok)   tmo_q <= tmo_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    gain_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q >= gain8_t'(GMIN8)) && (cur_q <= gain8_t'(GMAX8)));

    // R10
    gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(cur_q));

    // R2
    now_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && mode_e == CHG_NOW) |=> (cur_q == $past(tgt_s)));

    // R3
    zc_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && mode_e == CHG_ZC && !zc && !tmo_hit) |=> $stable(cur_q));

    // R5
    soft_step_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && mode[1]) |=> (cur_q == $past(cur_q) ||
                              cur_q == $past(cur_q) + gain8_t'(1) ||
                              cur_q == $past(cur_q) - gain8_t'(1)));
endmodule

// File: rtl/vol_scale.sv
module vol_scale
    import vol_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic [DW-1:0]     x,
    input  logic [GAIN_W-1:0] g,
    output logic [DW-1:0]     y
);
    localparam logic signed [63:0] YMAX = (64'sd1 <<< (DW - 1)) - 64'sd1;
    localparam logic signed [63:0] YMIN = -(64'sd1 <<< (DW - 1));

    logic [MANT_W-1:0] mtab [STEPS_6DB];

    for (genvar k = 0; k < STEPS_6DB; k++) begin : g_mant
        localparam logic [MANT_W-1:0] MK = mant_calc(k);
        assign mtab[k] = MK;
    end

    int                 e;
    int                 s;
    logic [5:0]         sh;
    logic [5:0]         idx;
    logic [MANT_W-1:0]  m;
    logic signed [63:0] p, r;

    always_comb begin
        e   = GMAX8 - int'($signed(g));
        sh  = 6'(e / STEPS_6DB);
        idx = 6'(e % STEPS_6DB);
        m   = mtab[idx];
        p   = $signed({{(64-DW){x[DW-1]}}, x}) * $signed({{(64-MANT_W){1'b0}}, m});
        s   = MANT_FRAC - HEAD + int'(sh);
        r   = (p + (64'sd1 <<< (s - 1))) >>> s;
        if (int'($signed(g)) <= GMIN8) y = '0;
        else if (r > YMAX)             y = YMAX[DW-1:0];
        else if (r < YMIN)             y = YMIN[DW-1:0];
        else                           y = r[DW-1:0];
    end
endmodule

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl
    import vol_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int DW     = 24,
    parameter int RATE_W = 8,
    parameter int ZC_TMO = 512
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        smp_vld,
    input  logic [NCH-1:0][DW-1:0]      smp_in,
    input  logic [INT_W-1:0]            mst_int,
    input  logic [FRAC_W-1:0]           mst_frac,
    input  logic [NCH-1:0][INT_W-1:0]   ch_int,
    input  logic [NCH-1:0][FRAC_W-1:0]  ch_frac,
    input  logic [NCH-1:0]              ch_mute,
    input  logic                        sngl_en,
    input  logic [1:0]                  chg_mode,
    input  logic [RATE_W-1:0]           ramp_rate,
    output logic                        out_vld,
    output logic [NCH-1:0][DW-1:0]      smp_out,
    output logic [NCH-1:0]              settled
);
    logic [NCH-1:0][GAIN_W-1:0] tgt;
    logic [NCH-1:0][GAIN_W-1:0] cur;
    logic [NCH-1:0][DW-1:0]     scaled;

    vol_target #(.NCH(NCH)) u_target (
        .mst_int  (mst_int),
        .mst_frac (mst_frac),
        .ch_int   (ch_int),
        .ch_frac  (ch_frac),
        .ch_mute  (ch_mute),
        .sngl_en  (sngl_en),
        .tgt      (tgt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vol_ramp #(.TMO(ZC_TMO), .RATE_W(RATE_W)) u_ramp (
            .clk     (clk),
            .rst     (rst),
            .vld     (smp_vld),
            .x_neg   (smp_in[c][DW-1]),
            .x_zero  (smp_in[c] == '0),
            .mode    (chg_mode),
            .rate    (ramp_rate),
            .tgt     (tgt[c]),
            .cur     (cur[c]),
            .settled (settled[c])
        );

        vol_scale #(.DW(DW)) u_scale (
            .x (smp_in[c]),
            .g (cur[c]),
            .y (scaled[c])
        );

        // R8
        mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (smp_vld && ch_mute[c] && settled[c]) |=> (smp_out[c] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            smp_out <= '0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) smp_out <= scaled;
        end
    end

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> out_vld);

    // R10
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !out_vld);
endmodule

// File: tb/sim_vol_ramp_ctrl.sv
module sim_vol_ramp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int DW  = 24;

    logic                      clk, rst, smp_vld, sngl_en, out_vld;
    logic [NCH-1:0][DW-1:0]    smp_in, smp_out;
    logic [7:0]                mst_int;
    logic [1:0]                mst_frac, chg_mode;
    logic [NCH-1:0][7:0]       ch_int;
    logic [NCH-1:0][1:0]       ch_frac;
    logic [NCH-1:0]            ch_mute, settled;
    logic [7:0]                ramp_rate;

    int checks = 0;
    int errors = 0;

    vol_ramp_ctrl #(.NCH(NCH), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
        .mst_int(mst_int), .mst_frac(mst_frac), .ch_int(ch_int), .ch_frac(ch_frac),
        .ch_mute(ch_mute), .sngl_en(sngl_en), .chg_mode(chg_mode),
        .ramp_rate(ramp_rate), .out_vld(out_vld), .smp_out(smp_out), .settled(settled)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    function automatic int gain8(int mi, int mf, int ci, int cf);
        int q;
        q = 4 * mi + mf + 4 * ci + cf;
        if (q > 96)   q = 96;
        if (q < -508) q = -508;
        return 2 * q;
    endfunction

    function automatic int model(int x, int g8);
        real v, lim;
        if (g8 <= -1016) return 0;
        lim = real'((1 << (DW - 1)) - 1);
        v = $floor(real'(x) * (2.0 ** (real'(g8) / 48.0)) + 0.5);
        if (v > lim)         return (1 << (DW - 1)) - 1;
        if (v < -lim - 1.0)  return -(1 << (DW - 1));
        return int'(v);
    endfunction

    task automatic chk_smp(int c, int exp, string tag);
        int act, diff, tol;
        act  = int'($signed(smp_out[c]));
        diff = act - exp;
        if (diff < 0) diff = -diff;
        tol  = 2 + ((exp < 0 ? -exp : exp) >>> 20);
        checks++;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s ch%0d actual %0d expected %0d", tag, c, act, exp);
        end
    endtask

    task automatic chk_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic frame();
        @(negedge clk);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic fill(int v);
        for (int c = 0; c < NCH; c++) smp_in[c] = DW'(v);
    endtask

    task automatic set_all(int mi, int mf, int ci, int cf);
        mst_int  = 8'(mi);
        mst_frac = 2'(mf);
        for (int c = 0; c < NCH; c++) begin
            ch_int[c]  = 8'(ci);
            ch_frac[c] = 2'(cf);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        int xs [NCH];
        int gs [NCH];
        int mi, mf;
        seed_init = $urandom(32'd4242);
        rst = 1'b1; smp_vld = 1'b0; sngl_en = 1'b0; chg_mode = 2'b00;
        ramp_rate = 8'd0; ch_mute = '0; fill(0); set_all(0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk_val("R11 out_vld", int'(out_vld), 0);
        chk_val("R11 settled", int'(settled), 0);
        chk_val("R11 smp_out", int'(smp_out == '0), 1);

        // R1/R2/R9/R10: random immediate-mode gains
        for (int it = 0; it < 40; it++) begin
            mi = int'($urandom_range(0, 60)) - 36;
            mf = int'($urandom_range(0, 3));
            mst_int = 8'(mi); mst_frac = 2'(mf);
            for (int c = 0; c < NCH; c++) begin
                ch_int[c]  = 8'(int'($urandom_range(0, 255)) - 128);
                ch_frac[c] = 2'($urandom_range(0, 3));
                gs[c] = gain8(mi, mf, int'($signed(ch_int[c])), int'(ch_frac[c]));
            end
            fill(int'($urandom_range(1, 1000)));
            frame();
            chk_val("R10 out_vld pulse", int'(out_vld), 1);
            chk_val("R9 settled after immediate", int'(settled), 6'h3f);
            for (int c = 0; c < NCH; c++) begin
                xs[c] = int'($urandom_range(0, (1 << DW) - 1)) - (1 << (DW - 1));
                smp_in[c] = DW'(xs[c]);
            end
            frame();
            for (int c = 0; c < NCH; c++) chk_smp(c, model(xs[c], gs[c]), "R2 R1 random gain");
            @(negedge clk);
            chk_val("R10 out_vld low", int'(out_vld), 0);
        end

        // R1: saturation corners
        set_all(24, 0, 24, 0); fill(1000); frame(); frame();
        chk_smp(0, 16000, "R1 +24 dB cap");
        set_all(-128, 0, -128, 0); frame(); frame();
        chk_smp(1, 0, "R1 floor clamp");
        set_all(0, 0, 0, 0); fill(8000000); frame();
        set_all(24, 0, 0, 0); frame(); frame();
        chk_smp(2, (1 << (DW - 1)) - 1, "R1 output saturation");

        // R7: single-volume mode
        set_all(0, 0, 10, 0); ch_int[0] = 8'(-6); sngl_en = 1'b1;
        fill(1 << 20); frame(); frame();
        for (int c = 0; c < NCH; c++) chk_smp(c, 1 << 19, "R7 follow channel 0");
        sngl_en = 1'b0;

        // R8: immediate mute
        set_all(0, 0, 0, 0); ch_mute[2] = 1'b1; fill(4096); frame(); frame();
        chk_smp(2, 0, "R8 muted channel zero");
        chk_smp(1, 4096, "R8 neighbour untouched");
        chk_val("R8 R9 muted settled", int'(settled[2]), 1);
        ch_mute = '0;

        // R3: zero-cross mode
        fill(5000); frame();
        chg_mode = 2'b01; ch_int[1] = 8'(-6); #1;
        chk_val("R9 pending after change", int'(settled[1]), 0);
        frame();
        chk_smp(1, 5000, "R3 held without crossing");
        chk_val("R3 still pending", int'(settled[1]), 0);
        fill(-5000); frame();
        chk_smp(1, -5000, "R3 crossing frame keeps old gain");
        chk_val("R3 settled after crossing", int'(settled[1]), 1);
        frame();
        chk_smp(1, -2500, "R3 new gain next frame");

        // R4: zero-cross timeout
        ch_int[1] = 8'(-12); fill(-8000);
        repeat (511) frame();
        chk_val("R4 pending at 511", int'(settled[1]), 0);
        chk_smp(1, -4000, "R4 gain held at 511");
        frame();
        chk_val("R4 forced at 512", int'(settled[1]), 1);
        frame();
        chk_smp(1, -2000, "R4 forced gain");

        // R5: soft ramp, rate 2 then rate 0
        chg_mode = 2'b00; ch_int[1] = 8'(0); fill(8192); frame();
        chg_mode = 2'b10; ramp_rate = 8'd2; ch_int[1] = 8'(-1);
        repeat (3) frame();
        frame();
        chk_smp(1, model(8192, -1), "R5 first eighth-dB step");
        repeat (19) frame();
        chk_val("R5 pending at 23 frames", int'(settled[1]), 0);
        frame();
        chk_val("R5 settled at 24 frames", int'(settled[1]), 1);
        ramp_rate = 8'd0; ch_int[1] = 8'(0);
        repeat (7) frame();
        chk_val("R5 rate0 pending at 7", int'(settled[1]), 0);
        frame();
        chk_val("R5 rate0 settled at 8", int'(settled[1]), 1);

        // R6: soft ramp gated by zero crossings
        chg_mode = 2'b11; ch_int[1] = 8'(-1); ch_frac[1] = 2'd3;
        repeat (5) frame();
        chk_val("R6 no step without crossing", int'(settled[1]), 0);
        chk_smp(1, 8192, "R6 gain unchanged");
        fill(-8192); frame();
        chk_smp(1, -8192, "R6 crossing frame old gain");
        frame();
        chk_smp(1, model(-8192, -1), "R6 one step taken");
        chk_val("R6 second step waits", int'(settled[1]), 0);
        fill(8192); frame();
        chk_val("R6 second crossing settles", int'(settled[1]), 1);
        ch_frac[1] = 2'd0; ch_int[1] = 8'(0);

        // R8: soft mute to floor
        chg_mode = 2'b00; fill(1 << 22); frame();
        chg_mode = 2'b10; ramp_rate = 8'd0; ch_mute[3] = 1'b1;
        repeat (1015) frame();
        chk_val("R8 soft mute pending", int'(settled[3]), 0);
        chk_val("R8 soft mute nonzero", int'(smp_out[3] != '0), 1);
        frame();
        chk_val("R8 soft mute settled", int'(settled[3]), 1);
        frame();
        chk_smp(3, 0, "R8 floor output zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule